// File: doc/BRIEF.md
# Test-Port Instruction Dispatcher with Calibration Sequencer

This block sits behind a boundary-scan test access port (TAP) controller. It watches the TAP state code and the current instruction value, and it decides when each instruction takes effect. One group of instructions acts at the moment the TAP reaches Update-IR. A second group waits until the TAP enters Run-Test/Idle. Each action is reported as a single-cycle start pulse on a dedicated output bit. The TAP controller and the data registers are not part of this block.

One instruction starts a self-timed calibration. The calibration first waits a fixed number of cycles for settling and then runs a fixed-length trim phase. After it starts it needs no more TAP activity, so the TAP may return to Test-Logic-Reset at once. For the whole calibration the block raises a control that forces every device output to zero. When the calibration ends, the block issues a done pulse.

Top module: `tap_dispatch`

## Requirements
- R1: TAP state codes are 4'hF for Test-Logic-Reset, 4'hC for Run-Test/Idle and 4'hD for Update-IR. In the first cycle that `tap_state` shows Update-IR after showing another state, the instruction value selects one bit of `upd_fire`. The mapping is 8'h01 to bit 0 (address), 8'hFF to bit 1 (bypass), 8'h00 to bit 2 (external test), 8'h16 to bit 3 (identification) and 8'h1C to bit 4 (sample/preload). That bit goes high for exactly the next cycle.
- R2: In the first cycle that `tap_state` shows Run-Test/Idle after showing another state, the instruction value selects one bit of `rti_fire`. The mapping is 8'h27 to bit 0 (program), 8'h2A to bit 1 (verify) and 8'h30 to bit 2 (bulk erase). That bit goes high for exactly the next cycle.
- R3: A start pulse follows only the transition into a state. Staying in Update-IR or Run-Test/Idle produces no further pulses. An instruction of one group produces nothing at the other group's event, and an unlisted instruction value produces nothing.
- R4: Entering Run-Test/Idle with instruction 8'h3C raises `cal_busy` in the next cycle. `cal_busy` then stays high for SETTLE_CYC + TRIM_CYC cycles.
- R5: `out_force_zero` is high in exactly the cycles in which `cal_busy` is high.
- R6: `cal_trim` is low during the first SETTLE_CYC busy cycles and high during the last TRIM_CYC busy cycles.
- R7: A calibration request made while `cal_busy` is high is ignored and does not lengthen the running calibration.
- R8: `cal_done` is high for one cycle, in the first cycle after `cal_busy` falls.
- R9: Once calibration has started, it runs to its end whatever `tap_state` does, including a return to Test-Logic-Reset.
- R10: While `rst` is high, every output is low and the last seen state is taken to be Test-Logic-Reset. Entering Run-Test/Idle or Update-IR in the first cycle after reset therefore counts as an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_state | input | 4 | Current TAP controller state code |
| ir_value | input | 8 | Current instruction register value |
| upd_fire | output | 5 | Start pulses for the Update-IR group |
| rti_fire | output | 3 | Start pulses for the Run-Test/Idle group |
| cal_busy | output | 1 | Calibration in progress |
| cal_trim | output | 1 | Calibration is in its trim phase |
| cal_done | output | 1 | One-cycle pulse when calibration ends |
| out_force_zero | output | 1 | Forces all device outputs to zero |

## Verification
Each start pulse appears in the cycle after the clock edge that first samples the target state. `cal_busy`, `cal_trim` and `out_force_zero` rise at that same point and fall SETTLE_CYC + TRIM_CYC edges later, and `cal_done` rises on that falling edge. The bench changes its inputs 1 ns after a rising edge. On each rising edge its behavioural model takes the sampled inputs and counts a remaining-cycle integer to the next expected outputs. The bench compares every output 1 ns after that edge, so the model and the design always refer to the same edge.

// File: rtl/tapdisp_pkg.sv
package tapdisp_pkg;
  localparam int ST_W  = 4;
  localparam int IR_W  = 8;
  localparam int N_UPD = 5;
  localparam int N_RTI = 3;

  localparam logic [ST_W-1:0] TAP_TLR    = 4'hF;
  localparam logic [ST_W-1:0] TAP_RTI    = 4'hC;
  localparam logic [ST_W-1:0] TAP_UPD_IR = 4'hD;

  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SETTLE = 2'd1,
    CAL_TRIM   = 2'd2
  } cal_phase_t;
endpackage

// File: rtl/tap_entry_detect.sv
module tap_entry_detect
  import tapdisp_pkg::*;
#(
  parameter int                       N_TGT   = 2,
  parameter logic [N_TGT*ST_W-1:0]    TARGETS = {TAP_RTI, TAP_UPD_IR}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] state,
  output logic [N_TGT-1:0] entered
);
  logic [ST_W-1:0] prev_state;

  always_ff @(posedge clk) begin
    if (rst) prev_state <= TAP_TLR;
    else     prev_state <= state;
  end

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    localparam logic [ST_W-1:0] CODE = TARGETS[g*ST_W +: ST_W];
    assign entered[g] = (state == CODE) && (prev_state != CODE);
  end
endmodule

// File: rtl/instr_group_decode.sv
module instr_group_decode
  import tapdisp_pkg::*;
#(
  parameter logic [IR_W-1:0] OP_ADDR   = 8'h01,
  parameter logic [IR_W-1:0] OP_BYPASS = 8'hFF,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OP_IDCODE = 8'h16,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h1C,
  parameter logic [IR_W-1:0] OP_PROG   = 8'h27,
  parameter logic [IR_W-1:0] OP_VERIFY = 8'h2A,
  parameter logic [IR_W-1:0] OP_ERASE  = 8'h30,
  parameter logic [IR_W-1:0] OP_CAL    = 8'h3C
) (
  input  logic [IR_W-1:0]  ir,
  output logic [N_UPD-1:0] upd_hit,
  output logic [N_RTI-1:0] rti_hit,
  output logic             cal_hit
);
  localparam logic [N_UPD*IR_W-1:0] UPD_CODES =
    {OP_SAMPLE, OP_IDCODE, OP_EXTEST, OP_BYPASS, OP_ADDR};
  localparam logic [N_RTI*IR_W-1:0] RTI_CODES =
    {OP_ERASE, OP_VERIFY, OP_PROG};

  for (genvar u = 0; u < N_UPD; u++) begin : g_upd
    assign upd_hit[u] = (ir == UPD_CODES[u*IR_W +: IR_W]);
  end

  for (genvar r = 0; r < N_RTI; r++) begin : g_rti
    assign rti_hit[r] = (ir == RTI_CODES[r*IR_W +: IR_W]);
  end

  assign cal_hit = (ir == OP_CAL);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import tapdisp_pkg::*;
#(
  parameter int SETTLE_CYC = 200,
  parameter int TRIM_CYC   = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic busy,
  output logic trim,
  output logic done,
  output logic force_zero
);
  localparam int MAX_CYC = (SETTLE_CYC > TRIM_CYC) ? SETTLE_CYC : TRIM_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TRIM_LAST   = CNT_W'(TRIM_CYC - 1);

  cal_phase_t       phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= CAL_IDLE;
      cnt        <= '0;
      done       <= 1'b0;
      force_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        CAL_IDLE: begin
          if (req) begin
            phase      <= CAL_SETTLE;
            cnt        <= '0;
            force_zero <= 1'b1;
          end
        end
        CAL_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            phase <= CAL_TRIM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CAL_TRIM: begin
          if (cnt == TRIM_LAST) begin
            phase      <= CAL_IDLE;
            cnt        <= '0;
            done       <= 1'b1;
            force_zero <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= CAL_IDLE;
      endcase
    end
  end

  assign busy = (phase != CAL_IDLE);
  assign trim = (phase == CAL_TRIM);
endmodule

// File: rtl/tap_dispatch.sv
module tap_dispatch
  import tapdisp_pkg::*;
#(
  parameter logic [IR_W-1:0] OP_ADDR    = 8'h01,
  parameter logic [IR_W-1:0] OP_BYPASS  = 8'hFF,
  parameter logic [IR_W-1:0] OP_EXTEST  = 8'h00,
  parameter logic [IR_W-1:0] OP_IDCODE  = 8'h16,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 8'h1C,
  parameter logic [IR_W-1:0] OP_PROG    = 8'h27,
  parameter logic [IR_W-1:0] OP_VERIFY  = 8'h2A,
  parameter logic [IR_W-1:0] OP_ERASE   = 8'h30,
  parameter logic [IR_W-1:0] OP_CAL     = 8'h3C,
  parameter int              SETTLE_CYC = 200,
  parameter int              TRIM_CYC   = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       tap_state,
  input  logic [7:0]       ir_value,
  output logic [4:0]       upd_fire,
  output logic [2:0]       rti_fire,
  output logic             cal_busy,
  output logic             cal_trim,
  output logic             cal_done,
  output logic             out_force_zero
);
  logic [1:0]       entered;
  logic [N_UPD-1:0] upd_hit;
  logic [N_RTI-1:0] rti_hit;
  logic             cal_hit;

  // entered[0] = Update-IR entry, entered[1] = Run-Test/Idle entry
  tap_entry_detect #(
    .N_TGT  (2),
    .TARGETS({TAP_RTI, TAP_UPD_IR})
  ) u_entry (
    .clk    (clk),
    .rst    (rst),
    .state  (tap_state),
    .entered(entered)
  );

  instr_group_decode #(
    .OP_ADDR  (OP_ADDR),   .OP_BYPASS(OP_BYPASS), .OP_EXTEST(OP_EXTEST),
    .OP_IDCODE(OP_IDCODE), .OP_SAMPLE(OP_SAMPLE), .OP_PROG  (OP_PROG),
    .OP_VERIFY(OP_VERIFY), .OP_ERASE (OP_ERASE),  .OP_CAL   (OP_CAL)
  ) u_dec (
    .ir     (ir_value),
    .upd_hit(upd_hit),
    .rti_hit(rti_hit),
    .cal_hit(cal_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_fire <= '0;
      rti_fire <= '0;
    end else begin
      upd_fire <= entered[0] ? upd_hit : '0;
      rti_fire <= entered[1] ? rti_hit : '0;
    end
  end

  cal_sequencer #(
    .SETTLE_CYC(SETTLE_CYC),
    .TRIM_CYC  (TRIM_CYC)
  ) u_cal (
    .clk       (clk),
    .rst       (rst),
    .req       (entered[1] & cal_hit),
    .busy      (cal_busy),
    .trim      (cal_trim),
    .done      (cal_done),
    .force_zero(out_force_zero)
  );
endmodule

// File: rtl/tapdisp_checker.sv
module tapdisp_checker
  import tapdisp_pkg::*;
#(
  parameter logic [IR_W-1:0] OP_CAL = 8'h3C
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] tap_state,
  input logic [7:0] ir_value,
  input logic [4:0] upd_fire,
  input logic [2:0] rti_fire,
  input logic       cal_busy,
  input logic       cal_trim,
  input logic       cal_done,
  input logic       out_force_zero
);
  assert_upd_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_fire));

  assert_upd_at_update_R1: assert property (@(posedge clk) disable iff (rst)
    (|upd_fire) |-> ($past(tap_state) == TAP_UPD_IR));

  assert_rti_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rti_fire));

  assert_rti_at_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (|rti_fire) |-> ($past(tap_state) == TAP_RTI));

  assert_no_retrigger_R3: assert property (@(posedge clk) disable iff (rst)
    ((|rti_fire) || (|upd_fire)) |=> (rti_fire == '0 && upd_fire == '0));

  assert_cal_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> ($past(tap_state) == TAP_RTI && $past(ir_value) == OP_CAL));

  assert_force_zero_R5: assert property (@(posedge clk) disable iff (rst)
    out_force_zero == cal_busy);

  assert_trim_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    cal_trim |-> cal_busy);

  assert_trim_to_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_trim) |-> !cal_busy);

  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> $fell(cal_busy));

  assert_fall_gives_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_busy) |-> cal_done);
endmodule

bind tap_dispatch tapdisp_checker #(.OP_CAL(OP_CAL)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tap_state     (tap_state),
  .ir_value      (ir_value),
  .upd_fire      (upd_fire),
  .rti_fire      (rti_fire),
  .cal_busy      (cal_busy),
  .cal_trim      (cal_trim),
  .cal_done      (cal_done),
  .out_force_zero(out_force_zero)
);

// File: tb/tap_dispatch_tb.sv
`timescale 1ns/1ps
module tap_dispatch_tb;
  localparam int S = 200;
  localparam int T = 300;
  localparam logic [3:0] TLR = 4'hF, RTI = 4'hC, UPD = 4'hD;
  localparam logic [3:0] CAP_IR = 4'hE, SEL_DR = 4'h7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tap_state = TLR;
  logic [7:0] ir_value = 8'h00;
  logic [4:0] upd_fire;
  logic [2:0] rti_fire;
  logic       cal_busy, cal_trim, cal_done, out_force_zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [3:0] m_prev = TLR;
  logic [4:0] m_upd = '0;
  logic [2:0] m_rti = '0;
  logic       m_done = 1'b0;
  int         m_left = 0;

  always #2.5 clk = ~clk;

  tap_dispatch u_dut (
    .clk(clk), .rst(rst), .tap_state(tap_state), .ir_value(ir_value),
    .upd_fire(upd_fire), .rti_fire(rti_fire), .cal_busy(cal_busy),
    .cal_trim(cal_trim), .cal_done(cal_done), .out_force_zero(out_force_zero)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic model_step();
    bit ent_u, ent_r;
    if (rst) begin
      m_prev = TLR; m_upd = '0; m_rti = '0; m_done = 1'b0; m_left = 0;
    end else begin
      ent_u = (tap_state == UPD) && (m_prev != UPD);
      ent_r = (tap_state == RTI) && (m_prev != RTI);
      m_upd = '0;
      m_rti = '0;
      if (ent_u) begin
        case (ir_value)
          8'h01: m_upd = 5'b00001;
          8'hFF: m_upd = 5'b00010;
          8'h00: m_upd = 5'b00100;
          8'h16: m_upd = 5'b01000;
          8'h1C: m_upd = 5'b10000;
          default: m_upd = '0;
        endcase
      end
      if (ent_r) begin
        case (ir_value)
          8'h27: m_rti = 3'b001;
          8'h2A: m_rti = 3'b010;
          8'h30: m_rti = 3'b100;
          default: m_rti = '0;
        endcase
      end
      m_done = 1'b0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_done = 1'b1;
      end else if (ent_r && ir_value == 8'h3C) begin
        m_left = S + T;
      end
      m_prev = tap_state;
    end
  endtask

  // one clock: model follows the edge, outputs compared 1 ns later
  task automatic tick();
    bit eb, et;
    @(posedge clk);
    model_step();
    #1;
    eb = (m_left > 0);
    et = eb && (m_left <= T);
    chk(upd_fire == m_upd, "R1", upd_fire, m_upd);
    chk(rti_fire == m_rti, "R2", rti_fire, m_rti);
    chk(cal_busy == eb, "R4", cal_busy, eb);
    chk(out_force_zero == eb, "R5", out_force_zero, eb);
    chk(cal_trim == et, "R6", cal_trim, et);
    chk(cal_done == m_done, "R8", cal_done, m_done);
  endtask

  task automatic go(input logic [3:0] st, input logic [7:0] ir, input int n);
    tap_state = st;
    ir_value = ir;
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: outputs low during reset
    go(TLR, 8'h00, 3);
    rst = 1'b0;
    // R10: Run-Test/Idle straight after reset counts as an entry (program)
    go(RTI, 8'h27, 1);
    chk(rti_fire == 3'b001, "R10", rti_fire, 3'b001);
    // R3: lingering in Run-Test/Idle gives no further pulse
    go(RTI, 8'h27, 5);
    chk(rti_fire == 3'b000, "R3", rti_fire, 0);
    // R1: each Update-IR instruction
    foreach (upd_ops[k]) begin
      go(CAP_IR, upd_ops[k], 2);
      go(UPD, upd_ops[k], 1);
      chk(upd_fire == (5'b1 << k), "R1", upd_fire, 5'b1 << k);
      go(UPD, upd_ops[k], 2);
    end
    // R2: verify and bulk erase
    go(SEL_DR, 8'h2A, 1); go(RTI, 8'h2A, 2);
    go(SEL_DR, 8'h30, 1); go(RTI, 8'h30, 2);
    // R3: wrong group and unknown opcodes do nothing
    go(CAP_IR, 8'h27, 1); go(UPD, 8'h27, 2);
    chk(upd_fire == 0 && rti_fire == 0, "R3", {upd_fire, rti_fire}, 0);
    go(SEL_DR, 8'h16, 1); go(RTI, 8'h16, 2);
    go(SEL_DR, 8'h55, 1); go(RTI, 8'h55, 1); go(UPD, 8'h55, 2);
    chk(upd_fire == 0 && rti_fire == 0, "R3", {upd_fire, rti_fire}, 0);
    // R4/R9: start calibration then move the TAP straight to reset state
    go(SEL_DR, 8'h3C, 1);
    go(RTI, 8'h3C, 1);
    chk(cal_busy == 1'b1, "R4", cal_busy, 1);
    go(TLR, 8'h00, 50);
    chk(cal_busy == 1'b1, "R9", cal_busy, 1);
    // R7: a second request mid-run is ignored; other instructions still fire
    go(RTI, 8'h3C, 3);
    go(SEL_DR, 8'h2A, 1); go(RTI, 8'h2A, 2);
    go(TLR, 8'h00, S + T);
    chk(cal_busy == 1'b0, "R7", cal_busy, 0);
    // R8: done already checked each cycle; start a second run, reset mid-way
    go(RTI, 8'h3C, 20);
    rst = 1'b1;
    go(TLR, 8'h00, 2);
    chk(cal_busy == 1'b0 && out_force_zero == 1'b0, "R10", cal_busy, 0);
    rst = 1'b0;
    go(TLR, 8'h00, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] upd_ops [5] = '{8'h01, 8'hFF, 8'h00, 8'h16, 8'h1C};
endmodule